// File: doc/BRIEF.md
# Clock-Windowed 1-of-8 I/O Decoder

This block turns a 3-bit device code into one of eight device-select lines for a small processor bus. A line is driven high only when three conditions hold together: the chip enable is high, an internal window flag is set, and the line's index equals the code. Boards with several of these decoders tie one address level to the chip enable of each. Each level then has its own set of eight selects, and one code can reach up to seven input and seven output devices per level.

Two timing-pulse inputs control the window flag. The falling edge of the open pulse sets the flag. The falling edge of the close pulse clears it. Between those edges the flag keeps its value, except that it is held clear whenever the open pulse is high while the close pulse is low.

Both pulses are asynchronous to the system clock. Each passes through a synchronizer chain before the block looks for its edges. The select lines are registered, and the code and the chip enable are sampled on every system clock. The pulse inputs are plain level pins with no handshake, because nothing in this block carries a stream.

Top module: `io_window_decoder`

## Requirements
- R1: While the window is open and the chip enable is high, `dev_sel` is one-hot with bit `sel` set, using a binary mapping: code 0 drives bit 0 and code 7 drives bit 7.
- R2: One cycle after the chip enable is sampled low, all eight select lines are low, whatever the code and pulse inputs are.
- R3: A falling edge on `pulse_open` opens the window. With the default two synchronizer stages, the selected line rises on the fourth rising clock edge after the pin falls, and is still low at the third.
- R4: A falling edge on `pulse_close` closes the window. The select lines go low on the fourth rising clock edge after the pin falls.
- R5: When no edge is detected and the open pulse is not high alone, the window keeps its previous state, so the outputs do not change.
- R6: While `pulse_open` is high and `pulse_close` is low, the window is forced closed, and all outputs go low at the same four-edge latency.
- R7: If both pulses fall in the same system cycle, the close wins and the window ends up closed.
- R8: The outputs are registered. A change of `sel` or `chip_en` shows on `dev_sel` exactly one clock later, and at most one bit of `dev_sel` is ever high.
- R9: A synchronous active-high reset closes the window and drives all select lines low on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Chip enable; low forces all selects low |
| sel | input | 3 | Device code |
| pulse_open | input | 1 | Asynchronous timing pulse; its falling edge opens the window |
| pulse_close | input | 1 | Asynchronous timing pulse; its falling edge closes the window |
| dev_sel | output | 8 | Registered one-hot device selects |

## Verification
Every cycle, the assertions compare the window flag with the edges and levels seen by the synchronizers. The flag must follow opens, closes, the forced-closed level and close priority, and hold in every other cycle. The assertions also check that the select lines match the previous cycle's code and gating, and that reset clears everything. Only the bench scenarios can show the latency from the pin, because it counts every synchronizer stage. The same goes for long holds with both pulses idle, and for sequences in which both pulses are raised and then dropped together.

// File: rtl/iowd_pkg.sv
package iowd_pkg;

  typedef enum logic [1:0] {
    WIN_HOLD  = 2'd0,
    WIN_OPEN  = 2'd1,
    WIN_CLOSE = 2'd2
  } win_cmd_e;

endpackage

// File: rtl/iowd_edge_sync.sv
// Synchronizer chain for an asynchronous pulse pin, with falling-edge detection.
module iowd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic fall
);

  logic prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic q;
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) q <= 1'b0;
          else     q <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) q <= 1'b0;
          else     q <= g_stage[i-1].q;
        end
      end
    end
  endgenerate

  assign level = g_stage[STAGES-1].q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  // A fall is a high previous sample followed by a low current one.
  assign fall = prev_q & ~level;

endmodule

// File: rtl/iowd_window_ctl.sv
// Window flag: set on an open fall, cleared on a close fall or while open is high alone.
module iowd_window_ctl
  import iowd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic open_lvl,
  input  logic open_fall,
  input  logic close_lvl,
  input  logic close_fall,
  output logic win_open
);

  win_cmd_e cmd;

  always_comb begin
    if (close_fall)                 cmd = WIN_CLOSE;
    else if (open_fall)             cmd = WIN_OPEN;
    else if (open_lvl && !close_lvl) cmd = WIN_CLOSE;
    else                            cmd = WIN_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_open <= 1'b0;
    end else begin
      case (cmd)
        WIN_OPEN:  win_open <= 1'b1;
        WIN_CLOSE: win_open <= 1'b0;
        default:   win_open <= win_open;
      endcase
    end
  end

endmodule

// File: rtl/iowd_onehot_dec.sv
// Registered binary-to-one-hot decoder with a gate.
module iowd_onehot_dec #(
  parameter int SEL_W = 3,
  localparam int OUT_W = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate,
  input  logic [SEL_W-1:0] sel,
  output logic [OUT_W-1:0] dev
);

  logic [OUT_W-1:0] hit;

  generate
    for (genvar i = 0; i < OUT_W; i++) begin : g_hit
      assign hit[i] = (sel == SEL_W'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       dev <= '0;
    else if (gate) dev <= hit;
    else           dev <= '0;
  end

endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder #(
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int OUT_W      = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chip_en,
  input  logic [SEL_W-1:0] sel,
  input  logic             pulse_open,
  input  logic             pulse_close,
  output logic [OUT_W-1:0] dev_sel
);

  logic a_lvl, a_fall, b_lvl, b_fall;
  logic win_open;
  logic gate;

  iowd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_open (
    .clk(clk), .rst(rst), .async_in(pulse_open), .level(a_lvl), .fall(a_fall)
  );

  iowd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_close (
    .clk(clk), .rst(rst), .async_in(pulse_close), .level(b_lvl), .fall(b_fall)
  );

  iowd_window_ctl u_win (
    .clk(clk), .rst(rst),
    .open_lvl(a_lvl), .open_fall(a_fall),
    .close_lvl(b_lvl), .close_fall(b_fall),
    .win_open(win_open)
  );

  assign gate = chip_en & win_open;

  iowd_onehot_dec #(.SEL_W(SEL_W)) u_dec (
    .clk(clk), .rst(rst), .gate(gate), .sel(sel), .dev(dev_sel)
  );

endmodule

// File: rtl/iowd_checker.sv
module iowd_checker #(
  parameter int SEL_W = 3,
  localparam int OUT_W = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst,
  input logic             chip_en,
  input logic [SEL_W-1:0] sel,
  input logic [OUT_W-1:0] dev_sel,
  input logic             win,
  input logic             lvl_a,
  input logic             fall_a,
  input logic             lvl_b,
  input logic             fall_b
);

  // R1
  decode_map_chk: assert property (@(posedge clk) disable iff (rst)
    $past(chip_en && win) |-> dev_sel == ({{(OUT_W-1){1'b0}}, 1'b1} << $past(sel)));

  // R2
  ce_low_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!chip_en) |-> dev_sel == '0);

  // R3
  open_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_a && !fall_b) |=> win);

  // R4
  close_clears_chk: assert property (@(posedge clk) disable iff (rst)
    fall_b |=> !win);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fall_a && !fall_b && !(lvl_a && !lvl_b)) |=> win == $past(win));

  // R6
  force_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_a && !lvl_b) |=> !win);

  // R7
  close_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_a && fall_b) |=> !win);

  // R8
  single_line_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_sel));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (dev_sel == '0 && !win));

endmodule

bind io_window_decoder iowd_checker #(.SEL_W(SEL_W)) u_iowd_chk (
  .clk(clk), .rst(rst), .chip_en(chip_en), .sel(sel), .dev_sel(dev_sel),
  .win(win_open), .lvl_a(a_lvl), .fall_a(a_fall), .lvl_b(b_lvl), .fall_b(b_fall)
);

// File: tb/tb_io_window_decoder.sv
`timescale 1ns/1ps
module tb_io_window_decoder;

  localparam int SEL_W = 3;
  localparam int SYNC  = 2;
  localparam int LAT   = SYNC + 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chip_en = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       pulse_open = 1'b0;
  logic       pulse_close = 1'b0;
  logic [7:0] dev_sel;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  int         q_cyc[$];
  logic [7:0] q_val[$];
  string      q_tag[$];

  io_window_decoder #(.SEL_W(SEL_W), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .chip_en(chip_en), .sel(sel),
    .pulse_open(pulse_open), .pulse_close(pulse_close), .dev_sel(dev_sel)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expected items whose cycle has come and compares them.
  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      int         c;
      logic [7:0] v;
      string      t;
      c = q_cyc.pop_front();
      v = q_val.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (c != cyc || dev_sel !== v) begin
        errors++;
        $display("FAIL %s cycle %0d: dev_sel=%b expected %b", t, cyc, dev_sel, v);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side: push an expected output n cycles ahead.
  task automatic expect_out(input int n, input logic [7:0] v, input string tag);
    q_cyc.push_back(cyc + n);
    q_val.push_back(v);
    q_tag.push_back(tag);
  endtask

  function automatic logic [7:0] oh(input logic [2:0] s);
    return 8'b1 << s;
  endfunction

  task automatic open_win(input logic [7:0] v);
    pulse_open = 1'b1;
    tick(LAT + 2);
    pulse_open = 1'b0;
    expect_out(LAT - 1, 8'h00, "R3 before latency");
    expect_out(LAT, v, "R3 open");
    tick(LAT + 1);
  endtask

  initial begin
    tick(3);
    rst = 1'b0; chip_en = 1'b1; sel = 3'd3;
    expect_out(1, 8'h00, "R9 reset state");
    tick(6);
    expect_out(1, 8'h00, "R5 no edge keeps closed");
    tick(2);

    open_win(oh(3'd3));

    // R1 and R8: every code, one cycle latency
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      expect_out(1, oh(3'(s)), "R1 decode map");
      tick(1);
    end

    // R2: chip enable low
    chip_en = 1'b0;
    expect_out(1, 8'h00, "R2 ce low");
    tick(1);
    sel = 3'd6;
    expect_out(1, 8'h00, "R2 ce low sel change");
    tick(1);
    chip_en = 1'b1;
    expect_out(1, oh(3'd6), "R8 ce back one cycle");
    tick(1);

    // R5: long idle hold, and close pulse high alone
    tick(20);
    expect_out(1, oh(3'd6), "R5 hold idle");
    tick(1);
    pulse_close = 1'b1;
    tick(LAT + 2);
    expect_out(1, oh(3'd6), "R5 close high holds");
    tick(1);

    // R4: close falls
    pulse_close = 1'b0;
    expect_out(LAT - 1, oh(3'd6), "R4 before latency");
    expect_out(LAT, 8'h00, "R4 close");
    tick(LAT + 1);

    // R6: reopen, then open pulse high alone forces closed
    sel = 3'd1;
    open_win(oh(3'd1));
    pulse_open = 1'b1;
    expect_out(LAT - 1, oh(3'd1), "R6 before latency");
    expect_out(LAT, 8'h00, "R6 forced closed");
    tick(LAT + 3);
    expect_out(1, 8'h00, "R6 stays closed");
    tick(1);
    pulse_open = 1'b0;
    expect_out(LAT, oh(3'd1), "R3 reopen after force");
    tick(LAT + 1);

    // R7: close first, raise both, drop together
    pulse_close = 1'b1;
    tick(3);
    pulse_close = 1'b0;
    expect_out(LAT, 8'h00, "R4 close before R7");
    tick(LAT + 1);
    pulse_close = 1'b1;
    tick(2);
    pulse_open = 1'b1;
    tick(LAT + 2);
    pulse_open = 1'b0; pulse_close = 1'b0;
    expect_out(LAT, 8'h00, "R7 close wins");
    expect_out(LAT + 4, 8'h00, "R7 stays closed");
    tick(LAT + 6);

    // R9: reset in an open window
    sel = 3'd7;
    open_win(oh(3'd7));
    rst = 1'b1;
    expect_out(1, 8'h00, "R9 reset mid window");
    tick(2);
    rst = 1'b0;
    expect_out(2, 8'h00, "R9 window closed after reset");
    tick(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule